// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. An internal divider produces a sample enable at sixteen times the baud rate. The divider ratio is worked out at elaboration from the system clock frequency and the requested baud rate, and it is rounded to the nearest integer. The line passes through a two-flop synchronizer. A falling edge opens a frame, and the start bit is confirmed at its middle before any data is taken. After that, every bit is sampled once at the centre of its period.

Each completed character goes to a downstream FIFO as a one-cycle write strobe with the data beside it. The FIFO reports back through a full flag. Three error strobes go out with the character. How an error affects the character depends on its type:

- A parity mismatch is reported, and the character is still stored.
- A bad stop bit drops the character.
- A full FIFO drops the character.

Top module: `serial_rx`

## Requirements
- R1: The bit period is 16*round(CLK_HZ/(16*BAUD)) clock cycles, with rounding to the nearest integer. The divider restarts at each accepted start edge.
- R2: While reset is held, and after it is released, every output (outData, outValid, parityErr, frameErr, overrunErr) is 0 until a frame completes.
- R3: A frame is one start bit (0), then DATA_W data bits with the least significant bit first, then an optional parity bit, then one stop bit (1). A good frame gives a one-cycle outValid pulse, and outData carries the character in its low DATA_W bits.
- R4: A low pulse on rxIn that has ended before the middle of the start bit produces no strobe of any kind.
- R5: With parity enabled, the parity bit makes the count of ones odd (PARITY_ODD=1) or even (PARITY_ODD=0) over the data plus parity bits. On a mismatch with an intact stop bit, parityErr pulses and the character is still written, unless the FIFO is full.
- R6: A stop bit sampled as 0 pulses frameErr. It gives no outValid and no parityErr.
- R7: If fifoFull is high when the stop bit is sampled, overrunErr pulses and outValid does not. This applies when the stop bit is good.
- R8: With PARITY_ON=0 there is no parity bit in the frame, and parityErr never asserts.
- R9: All strobes last one cycle. outValid never coincides with frameErr or overrunErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxIn | input | 1 | Asynchronous serial input, idle high |
| fifoFull | input | 1 | Downstream FIFO cannot accept a character |
| outData | output | DATA_W | Received character |
| outValid | output | 1 | One-cycle write strobe for outData |
| parityErr | output | 1 | One-cycle parity mismatch strobe |
| frameErr | output | 1 | One-cycle bad stop bit strobe |
| overrunErr | output | 1 | One-cycle character-dropped-on-full strobe |

## Verification
A wrong divider ratio or a sample counter that is off by one moves the sampling point across bit boundaries. The first frame after such a fault shows it as corrupted data or spurious frame errors. A control state machine stuck outside idle swallows the next frame entirely: a whole bit period passes with no strobe where one was expected. A wrong parity accumulator or a wrong drop rule shows on the strobes of the character in question, one cycle after its stop bit is sampled, well before the next frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic divClear;
    logic takeData;
    logic takeParity;
    logic takeStop;
  } rx_strobe_t;

endpackage

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV        = 54,
  parameter int PARITY_ON  = 1,
  parameter int PARITY_ODD = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxIn,
  input  logic              fifoFull,
  input  rx_strobe_t        strobes,
  output logic              tick,
  output logic              rxBit,
  output logic              startEdge,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);
  localparam logic ODD_WANT = (PARITY_ODD != 0);

  logic rxMeta, rxSync, rxPrev;
  logic [CW-1:0] divCnt;
  logic [DATA_W-1:0] shiftReg;
  logic parBit;
  logic mismatch;
  logic stopOk;

  // Two-flop synchronizer plus edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxBit     = rxSync;
  assign startEdge = rxPrev & ~rxSync;

  // Sample-enable divider
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || strobes.divClear || tick) divCnt <= '0;
    else                                 divCnt <= divCnt + 1'b1;
  end

  // Data shift register, LSB arrives first
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobes.takeData)   shiftReg <= {rxSync, shiftReg[DATA_W-1:1]};
      if (strobes.takeParity) parBit   <= rxSync;
    end
  end

  generate
    if (PARITY_ON != 0) begin : g_par
      assign mismatch = ((^shiftReg) ^ parBit) != ODD_WANT;
    end else begin : g_nopar
      assign mismatch = 1'b0;
    end
  endgenerate

  assign stopOk = rxSync;

  // Result strobes, one cycle after the stop sample
  always_ff @(posedge clk) begin
    if (rst) begin
      outData    <= '0;
      outValid   <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      outValid   <= strobes.takeStop & stopOk & ~fifoFull;
      parityErr  <= strobes.takeStop & stopOk & mismatch;
      frameErr   <= strobes.takeStop & ~stopOk;
      overrunErr <= strobes.takeStop & stopOk & fifoFull;
      if (strobes.takeStop && stopOk && !fifoFull) outData <= shiftReg;
    end
  end

endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PARITY_ON = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxBit,
  input  logic       startEdge,
  output rx_strobe_t strobes
);

  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);
  localparam logic [3:0] MID_SAMPLE = 4'd7;
  localparam logic [3:0] END_SAMPLE = 4'd15;

  rx_state_t state;
  logic [3:0] sampCnt;
  logic [BW-1:0] bitCnt;
  logic atBitEnd;

  assign atBitEnd = tick && (sampCnt == END_SAMPLE);

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: strobes.divClear   = startEdge;
      ST_DATA: strobes.takeData   = atBitEnd;
      ST_PAR:  strobes.takeParity = atBitEnd;
      ST_STOP: strobes.takeStop   = atBitEnd;
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sampCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sampCnt <= '0;
          bitCnt  <= '0;
          if (startEdge) state <= ST_START;
        end
        ST_START: if (tick) begin
          if (sampCnt == MID_SAMPLE) begin
            sampCnt <= '0;
            state   <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            sampCnt <= sampCnt + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == END_SAMPLE) begin
            if (bitCnt == BIT_LAST) state <= (PARITY_ON != 0) ? ST_PAR : ST_STOP;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_PAR: if (tick) begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == END_SAMPLE) state <= ST_STOP;
        end
        ST_STOP: if (tick) begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == END_SAMPLE) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int BAUD       = 115_200,
  parameter int DATA_W     = 8,
  parameter int PARITY_ON  = 1,
  parameter int PARITY_ODD = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxIn,
  input  logic              fifoFull,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);

  localparam int DIV_RAW = (CLK_HZ + 8 * BAUD) / (16 * BAUD);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  rx_strobe_t strobes;
  logic tick, rxBit, startEdge;

  serial_rx_ctrl #(
    .DATA_W   (DATA_W),
    .PARITY_ON(PARITY_ON)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rxBit    (rxBit),
    .startEdge(startEdge),
    .strobes  (strobes)
  );

  serial_rx_dp #(
    .DATA_W    (DATA_W),
    .DIV       (DIV),
    .PARITY_ON (PARITY_ON),
    .PARITY_ODD(PARITY_ODD)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rxIn      (rxIn),
    .fifoFull  (fifoFull),
    .strobes   (strobes),
    .tick      (tick),
    .rxBit     (rxBit),
    .startEdge (startEdge),
    .outData   (outData),
    .outValid  (outValid),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .overrunErr(overrunErr)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int PARITY_ON = 1
) (
  input logic clk,
  input logic rst,
  input logic fifoFull,
  input logic outValid,
  input logic parityErr,
  input logic frameErr,
  input logic overrunErr
);

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R9
  frame_excl_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !(frameErr || overrunErr));

  // R6
  frame_no_parity_chk: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> !parityErr);

  // R7
  overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
    overrunErr |-> $past(fifoFull));

  // R7
  write_not_full_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$past(fifoFull));

  // R5
  parity_stored_chk: assert property (@(posedge clk) disable iff (rst)
    parityErr |-> (outValid || overrunErr));

  // R8
  parity_off_chk: assert property (@(posedge clk) disable iff (rst)
    (PARITY_ON == 0) |-> !parityErr);

endmodule

bind serial_rx serial_rx_chk #(.PARITY_ON(PARITY_ON)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fifoFull  (fifoFull),
  .outValid  (outValid),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .overrunErr(overrunErr)
);

// File: tb/test_serial_rx.sv
module test_serial_rx;

  localparam int CLK_HZ  = 20_000_000;
  localparam int BAUD    = 333_000;
  localparam int DATA_W  = 7;
  // R1: rounded ratio (3.75 -> 4), so truncation would misread every frame
  localparam int BIT_CYC = 16 * ((CLK_HZ + 8 * BAUD) / (16 * BAUD));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxIn = 1'b1;
  logic fifoFull = 1'b0;
  logic [DATA_W-1:0] outData, npData;
  logic outValid, parityErr, frameErr, overrunErr;
  logic npValid, npParity, npFrame, npOverrun;

  int nCheck = 0;
  int nFail = 0;
  bit done = 1'b0;

  int cWr = 0, cPar = 0, cFrm = 0, cOvr = 0, cNpPar = 0;
  logic [DATA_W-1:0] lastData = '0;

  always #2 clk = ~clk;

  serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DATA_W),
              .PARITY_ON(1), .PARITY_ODD(1)) i_serial_rx (
    .clk(clk), .rst(rst), .rxIn(rxIn), .fifoFull(fifoFull),
    .outData(outData), .outValid(outValid), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr));

  serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DATA_W),
              .PARITY_ON(0), .PARITY_ODD(1)) i_serial_rx_np (
    .clk(clk), .rst(rst), .rxIn(rxIn), .fifoFull(fifoFull),
    .outData(npData), .outValid(npValid), .parityErr(npParity),
    .frameErr(npFrame), .overrunErr(npOverrun));

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin cWr++; lastData = outData; end
      if (parityErr)  cPar++;
      if (frameErr)   cFrm++;
      if (overrunErr) cOvr++;
      if (npParity)   cNpPar++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic oddBit(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  task automatic driveBit(input logic b);
    rxIn = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [DATA_W-1:0] d, input bit badPar,
                           input bit badStop, input bit full);
    int w0, p0, f0, o0;
    int expWr, expPar, expFrm, expOvr;
    @(negedge clk);
    fifoFull = full;
    w0 = cWr; p0 = cPar; f0 = cFrm; o0 = cOvr;
    driveBit(1'b0);
    for (int i = 0; i < DATA_W; i++) driveBit(d[i]);
    driveBit(oddBit(d) ^ badPar);
    driveBit(!badStop);
    driveBit(1'b1);
    driveBit(1'b1);
    expFrm = badStop ? 1 : 0;
    expOvr = (!badStop && full) ? 1 : 0;
    expWr  = (!badStop && !full) ? 1 : 0;
    expPar = (!badStop && badPar) ? 1 : 0;
    chk(cWr - w0 == expWr, "R3/R7 write count", cWr - w0, expWr);
    chk(cPar - p0 == expPar, "R5 parity strobe", cPar - p0, expPar);
    chk(cFrm - f0 == expFrm, "R6 frame strobe", cFrm - f0, expFrm);
    chk(cOvr - o0 == expOvr, "R7 overrun strobe", cOvr - o0, expOvr);
    if (expWr == 1) chk(lastData == d, "R3 data", int'(lastData), int'(d));
    fifoFull = 1'b0;
  endtask

  initial begin
    int w0, p0, f0, o0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R2: outputs while held in reset
    chk({outValid, parityErr, frameErr, overrunErr} == 4'b0, "R2 in reset",
        int'({outValid, parityErr, frameErr, overrunErr}), 0);
    rst = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    chk(cWr + cPar + cFrm + cOvr == 0, "R2 idle after reset", cWr + cPar + cFrm + cOvr, 0);
    chk(outData == '0, "R2 data reset", int'(outData), 0);

    // Directed corners: R1 R3 boundary values
    sendFrame(7'h00, 0, 0, 0);
    sendFrame(7'h7F, 0, 0, 0);
    sendFrame(7'h55, 0, 0, 0);
    // R5 mismatch stored
    sendFrame(7'h2A, 1, 0, 0);
    // R6 bad stop
    sendFrame(7'h13, 0, 1, 0);
    // R7 full
    sendFrame(7'h61, 0, 0, 1);
    // R5 plus R7 together
    sendFrame(7'h0F, 1, 0, 1);

    // R4 short glitch on the line
    w0 = cWr; p0 = cPar; f0 = cFrm; o0 = cOvr;
    rxIn = 1'b0;
    repeat (BIT_CYC / 3) @(negedge clk);
    rxIn = 1'b1;
    repeat (BIT_CYC * 14) @(negedge clk);
    chk((cWr - w0) + (cPar - p0) + (cFrm - f0) + (cOvr - o0) == 0, "R4 glitch ignored",
        (cWr - w0) + (cPar - p0) + (cFrm - f0) + (cOvr - o0), 0);
    sendFrame(7'h3C, 0, 0, 0);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'($urandom);
      sendFrame(d, ($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 6) == 0);
    end

    // R8: parity-free instance never flags parity
    chk(cNpPar == 0, "R8 no parity strobe", cNpPar, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCheck++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

endmodule